// File: doc/BRIEF.md
# Cartridge Bus Address Decoder

This block sits on the CPU side of a cartridge slot. For each access it chooses one of three targets: the ROM image held in on-chip memory, a one-bit serial EEPROM port, or a four-bit GPIO register window. It decodes byte, halfword and word accesses. Reads return their data one clock after the strobe. Writes to the GPIO window update its registers on the strobe edge. The EEPROM and GPIO devices live outside this block. It only produces their select strobes, passes the EEPROM write bit and holds the GPIO register values.

The EEPROM window depends on the configured ROM length. A large image gives up its top 256 bytes of cartridge space to the EEPROM. A small image instead places the EEPROM in the whole address page whose top byte is 0x0D. ROM bytes at offsets past the configured length are not zero. Each such byte is taken from a pattern computed from its own offset.

Top module: `cart_bus_decoder`

## Requirements
- R1: The ROM offset is the bus address masked to its low 25 bits. `rom_addr` carries this offset, so bus addresses that differ only above bit 24 read identical ROM data.
- R2: With `cfg_eeprom`=1 and `cfg_rom_len` > 0x100_0000, an access whose masked offset exceeds 0x1FF_FEFF selects the EEPROM (`eep_sel`=1) and not ROM. All other offsets still read ROM.
- R3: With `cfg_eeprom`=1 and `cfg_rom_len` <= 0x100_0000, any access with bus address bits 31:24 = 0x0D selects the EEPROM. With `cfg_eeprom`=0 the same address reads ROM.
- R4: An EEPROM write of any size raises `eep_we` and drives `eep_wbit` from bit 0 of the write data. An EEPROM read returns `eep_rbit` in bit 0 of `rd_data`, with bits 31:1 zero.
- R5: A ROM byte at offset i >= `cfg_rom_len` reads as byte (i & 1) of the 16-bit value (i >> 1) & 0xFFFF. Offsets 0..5 of an empty image therefore read 00,00,01,00,02,00.
- R6: `bus_size` encodes 0 = byte, 1 = halfword, 2 = word. A multi-byte ROM read is little-endian over consecutive offsets, and `rd_data` bits above the access size are zero.
- R7: GPIO registers sit at full bus addresses 0x0800_00C4 (data), 0x0800_00C6 (direction) and 0x0800_00C8 (control, 1 bit). Byte and halfword reads of these addresses return the register, zero-extended, only while control = 1. Otherwise, and for word reads, the access reads ROM.
- R8: A halfword write to one of the three GPIO addresses loads that register from write data bits 3:0, or bit 0 for control.
- R9: A word write to 0x0800_00C4 loads data from bits 3:0 and direction from bits 19:16. A word write to 0x0800_00C6 loads direction from bits 3:0 and control from bit 16.
- R10: A byte write outside the EEPROM window changes no GPIO register.
- R11: EEPROM routing takes priority over GPIO decoding, and a GPIO read hit takes priority over ROM. `eep_sel` and `gpio_sel` are never high together.
- R12: `rd_valid` is high exactly in the cycle after a cycle with `bus_rd` high. `rd_data` holds the result of that read until the next read.
- R13: After reset `rd_valid` = 0, `rd_data` = 0, and the GPIO registers hold data 0, direction 0xF and control 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rom_len | input | 26 | Loaded image length in bytes |
| cfg_eeprom | input | 1 | Backup memory is the serial EEPROM |
| bus_addr | input | 32 | Full bus byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rom_addr | output | 25 | ROM byte offset of lane 0 |
| rom_rdata | input | 32 | ROM bytes at offsets `rom_addr`+0..3, lane k in bits 8k+7:8k |
| eep_sel | output | 1 | EEPROM access strobe |
| eep_we | output | 1 | EEPROM write strobe |
| eep_wbit | output | 1 | EEPROM write bit |
| eep_rbit | input | 1 | EEPROM read bit |
| gpio_sel | output | 1 | GPIO access strobe |

## Verification
The bench checks `eep_sel`, `eep_we`, `eep_wbit`, `gpio_sel` and `rom_addr` in the same cycle as the strobe. These outputs are combinational, so it samples them one time unit after it drives the inputs on a falling edge. `rd_data` and `rd_valid` are registered and appear one rising edge after the read strobe. The bench drops the strobe on the next falling edge and samples there. A GPIO write takes effect on the rising edge that samples it, and the bench confirms it with a read issued on a later cycle.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    GREG_DATA = 2'd0,
    GREG_DIR  = 2'd1,
    GREG_CTL  = 2'd2,
    GREG_NONE = 2'd3
  } gpio_reg_e;

  // Byte returned for an offset past the image: half of (off >> 1).
  function automatic logic [7:0] filler_byte(input logic [31:0] off);
    logic [15:0] half;
    half = off[16:1];
    return off[0] ? half[15:8] : half[7:0];
  endfunction

  // Lanes kept for a given access size.
  function automatic logic [31:0] size_mask(input acc_size_e sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cbd_route.sv
module cbd_route
  import cbd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CART_AW    = 25,
  parameter logic [7:0]  EEP_PAGE   = 8'h0D,
  parameter logic [31:0] GPIO_BASE  = 32'h0800_00C4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  acc_size_e          size,
  input  logic               eep_mode,
  input  logic [CART_AW:0]   rom_len,
  input  logic               gpio_ctl,
  output logic [CART_AW-1:0] cart_off,
  output logic               eep_hit,
  output logic               gpio_addr_hit,
  output logic               gpio_rd_hit,
  output gpio_reg_e          gpio_reg
);

  localparam logic [CART_AW:0]   LARGE_LEN = (CART_AW+1)'(1) << (CART_AW - 1);
  localparam logic [CART_AW-1:0] EEP_FLOOR = ~CART_AW'(256);

  logic large_img;

  assign cart_off  = addr[CART_AW-1:0];
  assign large_img = rom_len > LARGE_LEN;

  always_comb begin
    eep_hit = 1'b0;
    if (eep_mode) begin
      if (large_img) eep_hit = cart_off > EEP_FLOOR;
      else           eep_hit = addr[ADDR_W-1 -: 8] == EEP_PAGE;
    end
  end

  always_comb begin
    if      (addr == GPIO_BASE)                gpio_reg = GREG_DATA;
    else if (addr == GPIO_BASE + ADDR_W'(2))   gpio_reg = GREG_DIR;
    else if (addr == GPIO_BASE + ADDR_W'(4))   gpio_reg = GREG_CTL;
    else                                       gpio_reg = GREG_NONE;
  end

  assign gpio_addr_hit = !eep_hit && (gpio_reg != GREG_NONE);
  assign gpio_rd_hit   = gpio_addr_hit && gpio_ctl && (size != SZ_WORD);

endmodule

// File: rtl/cbd_gpio_regs.sv
module cbd_gpio_regs
  import cbd_pkg::*;
#(
  parameter int unsigned GPIO_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  acc_size_e         size,
  input  gpio_reg_e         reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [GPIO_W-1:0] data_q,
  output logic [GPIO_W-1:0] dir_q,
  output logic              ctl_q
);

  localparam int unsigned HI = DATA_W / 2;

  logic ld_data, ld_dir, ld_ctl;
  logic [GPIO_W-1:0] data_d, dir_d;
  logic ctl_d;
  logic unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    ld_data = 1'b0; ld_dir = 1'b0; ld_ctl = 1'b0;
    data_d  = wdata[GPIO_W-1:0];
    dir_d   = wdata[GPIO_W-1:0];
    ctl_d   = wdata[0];
    if (wr_hit && size == SZ_HALF) begin
      ld_data = reg_sel == GREG_DATA;
      ld_dir  = reg_sel == GREG_DIR;
      ld_ctl  = reg_sel == GREG_CTL;
    end else if (wr_hit && size == SZ_WORD) begin
      if (reg_sel == GREG_DATA) begin
        ld_data = 1'b1;
        ld_dir  = 1'b1;
        dir_d   = wdata[HI +: GPIO_W];
      end else if (reg_sel == GREG_DIR) begin
        ld_dir  = 1'b1;
        ld_ctl  = 1'b1;
        ctl_d   = wdata[HI];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
      ctl_q  <= 1'b0;
    end else begin
      if (ld_data) data_q <= data_d;
      if (ld_dir)  dir_q  <= dir_d;
      if (ld_ctl)  ctl_q  <= ctl_d;
    end
  end

  // R10
  property byte_wr_stable_p;
    @(posedge clk) disable iff (!rst_n)
      (wr_hit && size == SZ_BYTE) |=> $stable({data_q, dir_q, ctl_q});
  endproperty
  byte_wr_stable_chk: assert property (byte_wr_stable_p);

  // R8
  property half_ctl_load_p;
    @(posedge clk) disable iff (!rst_n)
      (wr_hit && size == SZ_HALF && reg_sel == GREG_CTL) |=> (ctl_q == $past(wdata[0]));
  endproperty
  half_ctl_load_chk: assert property (half_ctl_load_p);

endmodule

// File: rtl/cbd_rom_lane.sv
module cbd_rom_lane
  import cbd_pkg::*;
#(
  parameter int unsigned CART_AW = 25,
  parameter int unsigned LANE    = 0
) (
  input  logic [CART_AW-1:0] base,
  input  logic [CART_AW:0]   rom_len,
  input  logic [7:0]         rom_byte,
  output logic [7:0]         lane_byte
);

  logic [CART_AW-1:0] off;
  logic in_image;

  assign off       = base + CART_AW'(LANE);
  assign in_image  = {1'b0, off} < rom_len;
  assign lane_byte = in_image ? rom_byte : filler_byte(32'(off));

endmodule

// File: rtl/cart_bus_decoder.sv
module cart_bus_decoder
  import cbd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CART_AW   = 25,
  parameter int unsigned GPIO_W    = 4,
  parameter logic [7:0]  EEP_PAGE  = 8'h0D,
  parameter logic [31:0] GPIO_BASE = 32'h0800_00C4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CART_AW:0]   cfg_rom_len,
  input  logic               cfg_eeprom,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic [CART_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0]  rom_rdata,
  output logic               eep_sel,
  output logic               eep_we,
  output logic               eep_wbit,
  input  logic               eep_rbit,
  output logic               gpio_sel
);

  localparam int unsigned LANES = DATA_W / 8;

  acc_size_e          size;
  logic [CART_AW-1:0] cart_off;
  logic               eep_hit, gpio_addr_hit, gpio_rd_hit;
  gpio_reg_e          gpio_reg;
  logic [GPIO_W-1:0]  gpio_data, gpio_dir;
  logic               gpio_ctl;
  logic [DATA_W-1:0]  rom_word, gpio_word, rd_next;

  assign size = acc_size_e'(bus_size);

  cbd_route #(
    .ADDR_W(ADDR_W), .CART_AW(CART_AW), .EEP_PAGE(EEP_PAGE), .GPIO_BASE(GPIO_BASE)
  ) u_route (
    .addr(bus_addr), .size(size), .eep_mode(cfg_eeprom), .rom_len(cfg_rom_len),
    .gpio_ctl(gpio_ctl), .cart_off(cart_off), .eep_hit(eep_hit),
    .gpio_addr_hit(gpio_addr_hit), .gpio_rd_hit(gpio_rd_hit), .gpio_reg(gpio_reg)
  );

  cbd_gpio_regs #(.GPIO_W(GPIO_W), .DATA_W(DATA_W)) u_gpio (
    .clk(clk), .rst_n(rst_n), .wr_hit(bus_wr && gpio_addr_hit), .size(size),
    .reg_sel(gpio_reg), .wdata(bus_wdata),
    .data_q(gpio_data), .dir_q(gpio_dir), .ctl_q(gpio_ctl)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    cbd_rom_lane #(.CART_AW(CART_AW), .LANE(k)) u_lane (
      .base(cart_off), .rom_len(cfg_rom_len),
      .rom_byte(rom_rdata[8*k +: 8]), .lane_byte(rom_word[8*k +: 8])
    );
  end

  assign rom_addr = cart_off;

  always_comb begin
    case (gpio_reg)
      GREG_DATA: gpio_word = DATA_W'(gpio_data);
      GREG_DIR:  gpio_word = DATA_W'(gpio_dir);
      GREG_CTL:  gpio_word = DATA_W'(gpio_ctl);
      default:   gpio_word = '0;
    endcase
  end

  always_comb begin
    if (eep_hit)          rd_next = DATA_W'(eep_rbit);
    else if (gpio_rd_hit) rd_next = gpio_word;
    else                  rd_next = rom_word & size_mask(size);
  end

  assign eep_sel  = eep_hit && (bus_rd || bus_wr);
  assign eep_we   = eep_hit && bus_wr;
  assign eep_wbit = eep_we && bus_wdata[0];
  assign gpio_sel = (bus_rd && gpio_rd_hit) || (bus_wr && gpio_addr_hit && size != SZ_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= rd_next;
    end
  end

  // R12
  property valid_follows_rd_p;
    @(posedge clk) disable iff (!rst_n) bus_rd |=> rd_valid;
  endproperty
  valid_follows_rd_chk: assert property (valid_follows_rd_p);

  // R12
  property no_spurious_valid_p;
    @(posedge clk) disable iff (!rst_n) rd_valid |-> $past(bus_rd);
  endproperty
  no_spurious_valid_chk: assert property (no_spurious_valid_p);

  // R11
  property sel_exclusive_p;
    @(posedge clk) disable iff (!rst_n) !(eep_sel && gpio_sel);
  endproperty
  sel_exclusive_chk: assert property (sel_exclusive_p);

  // R4
  property eep_read_narrow_p;
    @(posedge clk) disable iff (!rst_n)
      (bus_rd && eep_sel) |=> (rd_data[DATA_W-1:1] == '0);
  endproperty
  eep_read_narrow_chk: assert property (eep_read_narrow_p);

endmodule

// File: tb/test_cart_bus_decoder.sv
module test_cart_bus_decoder;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] cfg_rom_len = 26'h100;
  logic        cfg_eeprom = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [24:0] rom_addr;
  logic [31:0] rom_rdata;
  logic        eep_sel, eep_we, eep_wbit;
  logic        eep_rbit = 1'b0;
  logic        gpio_sel;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  cart_bus_decoder i_cart_bus_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_rom_len(cfg_rom_len), .cfg_eeprom(cfg_eeprom),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .eep_sel(eep_sel), .eep_we(eep_we),
    .eep_wbit(eep_wbit), .eep_rbit(eep_rbit), .gpio_sel(gpio_sel)
  );

  function automatic logic [7:0] img(input logic [24:0] i);
    return 8'(i[7:0] * 8'd7) ^ i[15:8] ^ 8'h5A;
  endfunction

  // ROM memory model: image content everywhere, the design applies the length.
  always_comb
    for (int k = 0; k < 4; k++) rom_rdata[8*k +: 8] = img(rom_addr + 25'(k));

  function automatic logic [7:0] exp_byte(input logic [24:0] i);
    if ({1'b0, i} < cfg_rom_len) return img(i);
    return i[0] ? i[16:9] : i[8:1];
  endfunction

  function automatic logic [31:0] exp_rom(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] r;
    int n;
    r = '0;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k++) r[8*k +: 8] = exp_byte(a[24:0] + 25'(k));
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One read: strobes sampled in-cycle, data sampled one edge later.
  task automatic do_read(input logic [31:0] a, input logic [1:0] sz,
                         output logic [31:0] d, output logic es, output logic gs);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    #1;
    es = eep_sel; gs = gpio_sel;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R12 valid", 32'(rd_valid), 32'd1);
    d = rd_data;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] w);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = w; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic es, gs;
    chk("R13 rd_valid", 32'(rd_valid), 0);
    chk("R13 rd_data", rd_data, 0);
    do_write(32'h0800_00C8, 2'd1, 32'h1);
    do_read(32'h0800_00C6, 2'd1, d, es, gs);
    chk("R13 dir", d, 32'hF);
    chk("R7 gpio_sel", 32'(gs), 1);
    do_read(32'h0800_00C4, 2'd1, d, es, gs);
    chk("R13 data", d, 32'h0);
    @(negedge clk);
    chk("R12 valid drops", 32'(rd_valid), 0);
  endtask

  task automatic t_rom;
    logic [31:0] d; logic es, gs;
    do_read(32'h0800_0010, 2'd2, d, es, gs);
    chk("R6 word", d, exp_rom(32'h10, 2'd2));
    do_read(32'h0A00_0010, 2'd2, d, es, gs);
    chk("R1 alias", d, exp_rom(32'h10, 2'd2));
    chk("R1 rom_addr", 32'(rom_addr), 32'h10);
    do_read(32'h0800_0021, 2'd1, d, es, gs);
    chk("R6 half", d, exp_rom(32'h21, 2'd1));
    do_read(32'h0800_0033, 2'd0, d, es, gs);
    chk("R6 byte", d, exp_rom(32'h33, 2'd0));
  endtask

  task automatic t_oob;
    logic [31:0] d; logic es, gs;
    cfg_rom_len = 26'h0;
    do_read(32'h0800_0000, 2'd2, d, es, gs);
    chk("R5 off0-3", d, 32'h0001_0000);
    do_read(32'h0800_0004, 2'd1, d, es, gs);
    chk("R5 off4-5", d, 32'h0000_0002);
    cfg_rom_len = 26'h100;
    do_read(32'h0800_00FE, 2'd2, d, es, gs);
    chk("R5 straddle", d, {8'h00, 8'h80, img(25'hFF), img(25'hFE)});
    do_read(32'h09FF_FFF3, 2'd0, d, es, gs);
    chk("R5 high", d, 32'hFF);
  endtask

  task automatic t_eeprom;
    logic [31:0] d; logic es, gs;
    cfg_eeprom = 1'b1; cfg_rom_len = 26'h40;
    eep_rbit = 1'b1;
    do_read(32'h0D00_0004, 2'd1, d, es, gs);
    chk("R3 sel", 32'(es), 1);
    chk("R4 rbit", d, 32'h1);
    do_read(32'h0800_0004, 2'd1, d, es, gs);
    chk("R3 outside", d, exp_rom(32'h4, 2'd1));
    @(negedge clk);
    bus_addr = 32'h0D00_0100; bus_size = 2'd0; bus_wdata = 32'hFFFF_FFF3; bus_wr = 1'b1;
    #1;
    chk("R4 we", 32'(eep_we), 1);
    chk("R4 wbit", 32'(eep_wbit), 1);
    bus_wdata = 32'h0000_FFFE;
    #1;
    chk("R4 wbit0", 32'(eep_wbit), 0);
    @(negedge clk);
    bus_wr = 1'b0;
    cfg_eeprom = 1'b0;
    do_read(32'h0D00_0004, 2'd1, d, es, gs);
    chk("R3 no backup", 32'(es), 0);
    chk("R3 no backup data", d, exp_rom(32'h0D00_0004, 2'd1));
    cfg_eeprom = 1'b1; cfg_rom_len = 26'h180_0000;
    eep_rbit = 1'b0;
    do_read(32'h09FF_FF00, 2'd1, d, es, gs);
    chk("R2 sel", 32'(es), 1);
    chk("R2 data", d, 32'h0);
    do_read(32'h09FF_FEFF, 2'd0, d, es, gs);
    chk("R2 below", 32'(es), 0);
    chk("R2 below data", d, exp_rom(32'h01FF_FEFF, 2'd0));
    do_read(32'h0D00_0000, 2'd1, d, es, gs);
    chk("R2 page ignored", 32'(es), 0);
    chk("R2 page data", d, exp_rom(32'h0D00_0000, 2'd1));
    cfg_eeprom = 1'b0; cfg_rom_len = 26'h100;
  endtask

  task automatic t_gpio;
    logic [31:0] d; logic es, gs;
    do_write(32'h0800_00C4, 2'd1, 32'h0000_ABCD);
    do_read(32'h0800_00C4, 2'd0, d, es, gs);
    chk("R8 data", d, 32'hD);
    chk("R11 gpio over rom", 32'(es), 0);
    do_write(32'h0800_00C4, 2'd2, 32'h000E_0005);
    do_read(32'h0800_00C4, 2'd1, d, es, gs);
    chk("R9 word data", d, 32'h5);
    do_read(32'h0800_00C6, 2'd1, d, es, gs);
    chk("R9 word dir", d, 32'hE);
    do_write(32'h0800_00C4, 2'd0, 32'h0000_00FA);
    do_write(32'h0800_00C6, 2'd0, 32'h0000_00F0);
    do_read(32'h0800_00C4, 2'd1, d, es, gs);
    chk("R10 data kept", d, 32'h5);
    do_read(32'h0800_00C6, 2'd1, d, es, gs);
    chk("R10 dir kept", d, 32'hE);
    do_read(32'h0800_00C4, 2'd2, d, es, gs);
    chk("R7 word falls to rom", d, exp_rom(32'hC4, 2'd2));
    chk("R7 word no sel", 32'(gs), 0);
    do_write(32'h0800_00C6, 2'd2, 32'h0000_0003);
    do_read(32'h0800_00C6, 2'd1, d, es, gs);
    chk("R7 gated off", d, exp_rom(32'hC6, 2'd1));
    chk("R7 gated no sel", 32'(gs), 0);
    do_write(32'h0800_00C6, 2'd2, 32'h0001_0009);
    do_read(32'h0800_00C8, 2'd1, d, es, gs);
    chk("R9 word ctl", d, 32'h1);
    do_read(32'h0800_00C6, 2'd0, d, es, gs);
    chk("R9 word dir2", d, 32'h9);
  endtask

  initial begin
    #(PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rom();
    t_oob();
    t_eeprom();
    t_gpio();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule